// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block is the bus-master engine that carries a single read or write from an internal requester onto an asynchronous-style external bus. It runs on a clock at twice the bus rate, and each tick of that clock is one half-state of the bus cycle. The block produces the bus clock itself. The cycle visits half-states S0 to S5. Pairs of wait half-states (W1, W2) are added for as long as the external device withholds its acknowledge. The block drives the address strobe, the data strobe, the read/write line, the address and the write data. It samples a transfer-acknowledge input and a bus-error input.

Chip-select logic can mark a cycle as fast with `cs_fast`, which is presented together with the request. A fast cycle does not wait for the acknowledge. It goes straight from S1 to S4, so it takes two bus clocks. The data strobe is not used for fast writes. At the end of every cycle the requester gets a one-tick done pulse, an error flag and the captured read data.

Top module: `bus_cycle_seq`

## Requirements
- R1: With the acknowledge present at the end of S2, a normal cycle occupies six ticks (S0,S1,S2,S3,S4,S5), and `done` is high in the tick after S5.
- R2: The active-low `dtack_n` is sampled only at the end of S2 and at the end of each W1. When it is high there, one W1,W2 pair (one bus clock) is inserted. A low level at any other tick has no effect on the cycle length.
- R3: When `cs_fast` is high at acceptance, the cycle is S0,S1,S4,S5, with `done` in the tick after S5. `dtack_n` is ignored for that cycle.
- R4: In a fast write, `ds_n` stays high for the whole cycle. In a fast read, `ds_n` is low in S1 and S4.
- R5: `as_n` is low from S1 through S4, including wait ticks. For reads `ds_n` follows `as_n`. For normal writes `ds_n` is low from S3 through S4. `addr` holds the accepted address throughout the cycle.
- R6: For a read, `rdata` takes the value present on `data_in` during S4 and presents it with `done`.
- R7: The active-low `berr_n` is sampled only at the end of S4. If it is low there, `err` is high together with `done`. It is sampled at the same point in fast cycles.
- R8: `rw_n` is low from S0 through S5 of a write. `data_oe` is high and `data_out` equals the write data from S2 (S4 for a fast write) through S5. Both are inactive for reads.
- R9: `req_ready` is high only when the block is idle and `bus_clk` is low. `done` lasts one tick. `cs_fast` is taken only at acceptance, and changes on it during a cycle have no effect.
- R10: `bus_clk` toggles every tick and is high in S0, S2, W1 and S4.
- R11: After reset, `as_n`, `ds_n` and `rw_n` are high, `data_oe`, `done` and `bus_clk` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-state clock (twice the bus clock rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester has a transfer to run |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| cs_fast | input | 1 | Fast-termination enable from chip-select match |
| req_ready | output | 1 | Request taken on this tick when high with req_valid |
| done | output | 1 | One-tick completion pulse |
| err | output | 1 | Cycle ended by bus error (valid with done) |
| rdata | output | DW | Captured read data |
| bus_clk | output | 1 | Generated bus clock |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | High for read, low for write |
| addr | output | AW | Bus address |
| data_out | output | DW | Bus write data |
| data_oe | output | 1 | Write data output enable |
| data_in | input | DW | Bus read data |
| dtack_n | input | 1 | Transfer acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |

## Verification
The assertions assume that `dtack_n` and `berr_n` are already synchronous to `clk`. They also assume that every normal cycle eventually receives its acknowledge, because the block has no timeout. The bench changes all inputs only at the falling edge of `clk`. It schedules the acknowledge for each normal cycle at a chosen sample point and holds it through S5. It adds acknowledge and bus-error pulses only at ticks where the requirements say they are ignored, and it toggles `cs_fast` during busy cycles.

// File: rtl/bcs_pkg.sv
// Shared state type and half-state classification helpers for the
// bus cycle sequencer. Assumes one clk tick per bus half-state.
package bcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_S0   = 4'd1,
        ST_S1   = 4'd2,
        ST_S2   = 4'd3,
        ST_S3   = 4'd4,
        ST_W1   = 4'd5,
        ST_W2   = 4'd6,
        ST_S4   = 4'd7,
        ST_S5   = 4'd8
    } bcs_state_e;

    // Address strobe window: S1 through S4, wait ticks included.
    function automatic logic in_strobe_window(bcs_state_e s);
        return (s == ST_S1) || (s == ST_S2) || (s == ST_S3) ||
               (s == ST_W1) || (s == ST_W2) || (s == ST_S4);
    endfunction

    // Window in which a normal write asserts its data strobe.
    function automatic logic in_write_ds_window(bcs_state_e s);
        return (s == ST_S3) || (s == ST_W1) || (s == ST_W2) || (s == ST_S4);
    endfunction

    // Window in which write data is driven: S2 through S5.
    function automatic logic in_drive_window(bcs_state_e s);
        return (s == ST_S2) || (s == ST_S3) || (s == ST_W1) ||
               (s == ST_W2) || (s == ST_S4) || (s == ST_S5);
    endfunction

endpackage

// File: rtl/bcs_seq.sv
// Half-state sequencer. Owns the cycle state and the bus clock phase.
// Assumes: fire only when idle with phase low, fast_q stable for the
// whole cycle, ack_ok reflects the latest S2/W1 acknowledge sample.
module bcs_seq
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       fast_q,
    input  logic       ack_ok,
    output bcs_state_e state,
    output logic       phase
);

    bcs_state_e state_nx;

    // Next half-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (fire) state_nx = ST_S0;
            ST_S0:   state_nx = ST_S1;
            ST_S1:   state_nx = fast_q ? ST_S4 : ST_S2;
            ST_S2:   state_nx = ST_S3;
            ST_S3:   state_nx = ack_ok ? ST_S4 : ST_W1;
            ST_W1:   state_nx = ST_W2;
            ST_W2:   state_nx = ack_ok ? ST_S4 : ST_W1;
            ST_S4:   state_nx = ST_S5;
            ST_S5:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Free-running bus clock phase, one toggle per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    AST_FAST_SKIPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S1 && fast_q) |=> (state == ST_S4)); // R3
    AST_WAIT_ON_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_S3 || state == ST_W2) && !ack_ok) |=> (state == ST_W1)); // R2
    AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S0 || state == ST_S2 || state == ST_W1 || state == ST_S4) |-> phase); // R10

endmodule

// File: rtl/bcs_sampler.sv
// Samples the acknowledge and bus-error inputs at the end of the
// high half-states where the protocol looks at them.
// Assumes dtack_n and berr_n are synchronous to clk.
module bcs_sampler
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bcs_state_e state,
    input  logic       dtack_n,
    input  logic       berr_n,
    output logic       ack_ok,
    output logic       berr_hit
);

    // Acknowledge sample at the end of S2 and of each W1; cleared at S0.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ack_ok <= 1'b0;
        else if (state == ST_S0)                  ack_ok <= 1'b0;
        else if (state == ST_S2 || state == ST_W1) ack_ok <= ~dtack_n;
    end

    // Bus-error sample at the end of S4, one bus clock after acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)              berr_hit <= 1'b0;
        else if (state == ST_S0) berr_hit <= 1'b0;
        else if (state == ST_S4) berr_hit <= ~berr_n;
    end

    AST_ACK_HELD_OUTSIDE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S3 || state == ST_W2 || state == ST_S4) |=> $stable(ack_ok)); // R2

endmodule

// File: rtl/bcs_req_latch.sv
// Request capture and completion datapath: holds address, write data,
// direction and fast flag for the cycle, captures read data at S4 and
// issues the one-tick done pulse with the error flag.
// Assumes fire is only raised when the sequencer is idle.
module bcs_req_latch
    import bcs_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          cs_fast,
    input  bcs_state_e    state,
    input  logic          berr_hit,
    input  logic [DW-1:0] data_in,
    output logic          write_q,
    output logic          fast_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata,
    output logic          done,
    output logic          err
);

    // Request fields latched once at acceptance, held for the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            fast_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (fire) begin
            write_q <= req_write;
            fast_q  <= cs_fast;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read data capture at the end of S4.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rdata <= '0;
        else if (state == ST_S4 && !write_q) rdata <= data_in;
    end

    // Completion pulse and error flag, raised in the tick after S5.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= (state == ST_S5);
            err  <= (state == ST_S5) && berr_hit;
        end
    end

    AST_DONE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R7
    AST_FAST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_S0) |-> $stable(fast_q)); // R9

endmodule

// File: rtl/bcs_strobe_dec.sv
// Decodes the bus control lines from the half-state and the latched
// direction and fast flag. Pure decode of registered state.
module bcs_strobe_dec
    import bcs_pkg::*;
(
    input  bcs_state_e state,
    input  logic       write_q,
    input  logic       fast_q,
    output logic       as_n,
    output logic       ds_n,
    output logic       rw_n,
    output logic       data_oe
);

    logic as_on;
    logic ds_on;

    // Strobe windows per direction; fast writes never use the data strobe.
    always_comb begin
        as_on   = in_strobe_window(state);
        ds_on   = write_q ? (!fast_q && in_write_ds_window(state)) : as_on;
        as_n    = ~as_on;
        ds_n    = ~ds_on;
        rw_n    = ~(write_q && state != ST_IDLE);
        data_oe = write_q && in_drive_window(state);
    end

endmodule

// File: rtl/bus_cycle_seq.sv
// External bus cycle sequencer top. Joins the half-state sequencer,
// the input sampler, the request latch and the strobe decoder.
// Assumes clk runs at twice the bus rate and inputs are synchronous.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          cs_fast,
    output logic          req_ready,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic          bus_clk,
    output logic          as_n,
    output logic          ds_n,
    output logic          rw_n,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    input  logic [DW-1:0] data_in,
    input  logic          dtack_n,
    input  logic          berr_n
);

    bcs_state_e    state;
    logic          phase;
    logic          fire;
    logic          ack_ok;
    logic          berr_hit;
    logic          write_q;
    logic          fast_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    // Accept only when idle and the next tick starts a high bus phase.
    always_comb begin
        req_ready = (state == ST_IDLE) && !phase;
        fire      = req_ready && req_valid;
        bus_clk   = phase;
        addr      = addr_q;
        data_out  = wdata_q;
    end

    bcs_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .fast_q (fast_q),
        .ack_ok (ack_ok),
        .state  (state),
        .phase  (phase)
    );

    bcs_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .dtack_n  (dtack_n),
        .berr_n   (berr_n),
        .ack_ok   (ack_ok),
        .berr_hit (berr_hit)
    );

    bcs_req_latch #(.AW(AW), .DW(DW)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cs_fast   (cs_fast),
        .state     (state),
        .berr_hit  (berr_hit),
        .data_in   (data_in),
        .write_q   (write_q),
        .fast_q    (fast_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata     (rdata),
        .done      (done),
        .err       (err)
    );

    bcs_strobe_dec u_dec (
        .state   (state),
        .write_q (write_q),
        .fast_q  (fast_q),
        .as_n    (as_n),
        .ds_n    (ds_n),
        .rw_n    (rw_n),
        .data_oe (data_oe)
    );

    AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> !as_n); // R5
    AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !rw_n); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && $past(!as_n)) |-> $stable(addr)); // R5
    AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> !req_ready); // R9

endmodule

// File: tb/bus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb_top;

    localparam int AW = 24;
    localparam int DW = 16;

    localparam int L_S0 = 0;
    localparam int L_S1 = 1;
    localparam int L_S2 = 2;
    localparam int L_S3 = 3;
    localparam int L_W1 = 4;
    localparam int L_W2 = 5;
    localparam int L_S4 = 6;
    localparam int L_S5 = 7;

    typedef struct {
        bit            wr;
        bit            fast;
        int            waits;
        bit            berr;
        bit            noise;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } job_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          cs_fast = 1'b0;
    logic          req_ready;
    logic          done;
    logic          err;
    logic [DW-1:0] rdata;
    logic          bus_clk;
    logic          as_n;
    logic          ds_n;
    logic          rw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic [DW-1:0] data_in = '0;
    logic          dtack_n = 1'b1;
    logic          berr_n = 1'b1;

    int checks = 0;
    int failures = 0;

    // Reference model state
    job_t          pend[$];
    job_t          cur;
    int            q[$];
    int            pos = 0;
    bit            m_phase = 1'b0;
    bit            m_done = 1'b0;
    bit            m_err = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    bit            m_last_rd = 1'b0;
    bit            m_berr_s4 = 1'b0;

    always #5 clk = ~clk;

    bus_cycle_seq #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cs_fast(cs_fast),
        .req_ready(req_ready), .done(done), .err(err), .rdata(rdata),
        .bus_clk(bus_clk), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .addr(addr),
        .data_out(data_out), .data_oe(data_oe), .data_in(data_in),
        .dtack_n(dtack_n), .berr_n(berr_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic add_job(input bit wr, input bit fast, input int waits, input bit berr,
                           input bit noise, input logic [AW-1:0] a, input logic [DW-1:0] d);
        job_t j;
        j.wr = wr; j.fast = fast; j.waits = waits; j.berr = berr;
        j.noise = noise; j.a = a; j.d = d;
        pend.push_back(j);
    endtask

    // One tick of the model: check outputs, drive inputs, predict next tick.
    task automatic step();
        bit idle;
        int lab;
        bit e_as, e_ds, e_oe, fire, next_done;
        int fin;
        string ttag;
        idle = (q.size() == 0);
        lab  = idle ? -1 : q[0];

        e_as = !idle && (lab >= L_S1) && (lab <= L_S4);
        if (idle)        e_ds = 1'b0;
        else if (!cur.wr) e_ds = e_as;
        else             e_ds = !cur.fast && (lab == L_S3 || lab == L_W1 || lab == L_W2 || lab == L_S4);
        e_oe = !idle && cur.wr && (lab >= L_S2);

        chk("R10", "bus_clk", bus_clk, m_phase);
        chk("R9", "req_ready", req_ready, idle && !m_phase);
        chk("R5", "as_n", as_n, !e_as);
        chk((cur.wr && cur.fast) ? "R4" : "R5", "ds_n", ds_n, !e_ds);
        chk("R8", "rw_n", rw_n, !(!idle && cur.wr));
        chk("R8", "data_oe", data_oe, e_oe);
        if (e_oe) chk("R8", "data_out", data_out, cur.d);
        if (!idle) chk("R5", "addr", addr, cur.a);
        ttag = cur.fast ? "R3" : ((cur.waits > 0) ? "R2" : "R1");
        chk(ttag, "done", done, m_done);
        if (m_done) begin
            chk("R7", "err", err, m_err);
            if (m_last_rd) chk("R6", "rdata", rdata, m_rdata);
        end

        // Drive inputs for this tick
        dtack_n = 1'b1;
        berr_n  = 1'b1;
        data_in = ~cur.d ^ 16'h5A5A;
        fire    = 1'b0;
        if (idle) begin
            if (pend.size() > 0) begin
                req_valid = 1'b1;
                req_write = pend[0].wr;
                req_addr  = pend[0].a;
                req_wdata = pend[0].d;
                cs_fast   = pend[0].fast;
                fire      = !m_phase;
            end else begin
                req_valid = 1'b0;
            end
        end else begin
            req_valid = 1'b0;
            cs_fast   = !cur.fast;          // R9: ignored while busy
            req_addr  = ~cur.a;
            fin = 2 + 2 * cur.waits;
            if (cur.fast) begin
                if (cur.noise) dtack_n = 1'b0;  // R3: ignored in fast cycles
            end else if (pos >= fin) begin
                dtack_n = 1'b0;
            end else if (cur.noise && (pos % 2 == 1)) begin
                dtack_n = 1'b0;                 // R2: off-sample ack ignored
            end
            if (lab == L_S4) begin
                berr_n  = !cur.berr;
                data_in = cur.d;
            end else if (cur.noise && (lab == L_S1 || lab == L_S2 || lab == L_S3 || lab == L_S5)) begin
                berr_n = 1'b0;                  // R7: off-sample error ignored
            end
        end

        // Predict next tick
        next_done = 1'b0;
        if (fire) begin
            cur = pend.pop_front();
            q.push_back(L_S0);
            q.push_back(L_S1);
            if (!cur.fast) begin
                q.push_back(L_S2);
                q.push_back(L_S3);
                for (int w = 0; w < cur.waits; w++) begin
                    q.push_back(L_W1);
                    q.push_back(L_W2);
                end
            end
            q.push_back(L_S4);
            q.push_back(L_S5);
            pos = 0;
        end else if (!idle) begin
            if (lab == L_S4) begin
                m_berr_s4 = cur.berr;
                if (!cur.wr) m_rdata = cur.d;
            end
            void'(q.pop_front());
            pos++;
            if (q.size() == 0) begin
                next_done = 1'b1;
                m_err     = m_berr_s4;
                m_last_rd = !cur.wr;
            end
        end
        m_done  = next_done;
        m_phase = !m_phase;
    endtask

    initial begin
        cur = '{wr:0, fast:0, waits:0, berr:0, noise:0, a:'0, d:'0};
        add_job(0, 0, 0, 0, 0, 24'h000100, 16'h1234);   // R1 read
        add_job(1, 0, 0, 0, 0, 24'h000204, 16'hBEEF);   // R1 write
        add_job(0, 0, 1, 0, 1, 24'h003000, 16'hA5C3);   // R2 one wait
        add_job(1, 0, 3, 0, 1, 24'h0A0A0A, 16'h0F0F);   // R2 three waits
        add_job(0, 1, 0, 0, 0, 24'hFFFFFE, 16'h8001);   // R3 fast read
        add_job(1, 1, 0, 0, 0, 24'h123456, 16'h7777);   // R4 fast write
        add_job(0, 1, 0, 0, 1, 24'h00FF00, 16'hC0DE);   // R3 fast read noisy
        add_job(1, 1, 0, 1, 1, 24'h000010, 16'h2468);   // R7 fast write error
        add_job(0, 0, 0, 1, 0, 24'h040000, 16'hFACE);   // R7 read error
        add_job(1, 0, 2, 1, 1, 24'h050505, 16'h1357);   // R7 write error waits
        add_job(0, 0, 2, 0, 1, 24'h060000, 16'h0000);   // R6 read waits
        add_job(0, 0, 0, 0, 1, 24'h070000, 16'hFFFF);   // R2 noisy zero wait
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11", "reset as_n", as_n, 1'b1);
        chk("R11", "reset ds_n", ds_n, 1'b1);
        chk("R11", "reset rw_n", rw_n, 1'b1);
        chk("R11", "reset data_oe", data_oe, 1'b0);
        chk("R11", "reset done", done, 1'b0);
        chk("R11", "reset bus_clk", bus_clk, 1'b0);
        chk("R11", "reset req_ready", req_ready, 1'b1);
        step();
        while (pend.size() > 0 || q.size() > 0 || m_done) begin
            @(negedge clk);
            step();
        end
        repeat (4) begin
            @(negedge clk);
            step();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule